// File: doc/BRIEF.md
# Iterative 128-bit Block Decryption Core

This core turns one 128-bit ciphertext block back into plaintext for a 32-round substitution-permutation cipher. The rounds run backwards, one per clock. A round applies one of eight 4-bit inverse substitution boxes in bitsliced form across the four 32-bit state words, XORs in a round key, and then applies the inverse linear mixing step. A separate subsystem expands the key and writes the 33 round keys into the core's internal key store through a plain word-write port. The rounds read those keys from index 32 down to index 0.

A controller with three states steps the core. In **IDLE**, a `start` pulse captures `ct_in` XORed with key 32 (transition IDLE→ROUND). **ROUND** runs one reverse round per cycle while the round index falls from 31 to 0. The cycle that processes index 0 leaves for **EMIT** (ROUND→EMIT). EMIT registers the plaintext, raises `out_valid` for one cycle and returns to IDLE (EMIT→IDLE). `start` has no effect in ROUND and in EMIT.

Top module: `blkdec_core`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `pt_out` is all zeros, and the core is idle.
- R2: A `start` seen in IDLE is accepted. A `start` during ROUND or EMIT is ignored: the running result, its timing and the number of output pulses do not change.
- R3: `out_valid` is high for exactly one cycle. It rises on the 33rd rising edge after the edge that accepted `start`.
- R4: The result is the inverse of the forward cipher, in which round r (0..31) XORs key r, applies forward box r mod 8 and then the forward mixing step, except that round 31 replaces the mixing step with an XOR of key 32. Decryption XORs key 32 first. Then, for r from 31 down to 0, it applies inverse box r mod 8 and XORs key r, and for r > 0 it follows with the inverse mixing step.
- R5: The inverse mixing step, on words x0..x3, in this order: rotate x0 right 5 and x2 right 22; x2 ^= x3 ^ (x1 << 7); x0 ^= x1 ^ x3; rotate x1 right 1 and x3 right 7; x3 ^= x2 ^ (x0 << 3); x1 ^= x0 ^ x2; rotate x0 right 13 and x2 right 3.
- R6: Each inverse box is the exact inverse permutation of its forward box. Forward box k is a 64-bit constant in which the output for input v sits at bits 4v+3:4v. The constants, for k = 0..7, are C90724DEB56A1F83, 43D68EB1A50972CF, 25B04E1DFAC39768, E57A421D369C8BF0, D7E9A4526B0C38F1, 176D8E30C9A4B25F, 0A3DF19EB6485C27, 6539AC47B28E0FD1. The boxes act on the nibble {x3[b],x2[b],x1[b],x0[b]} of every bit position b, with x0 as the least significant bit.
- R7: A write with `key_we` high stores `key_wdata` at word address `key_addr` on the rising edge. Word j of round key i lives at address 4*i+j. Addresses of 132 and above are dropped.
- R8: On both `ct_in` and `pt_out`, word j sits at bits 32j+31:32j.
- R9: `pt_out` keeps its value until the next `out_valid` pulse, including while a new block is being decrypted.
- R10: A `start` in the same cycle as `out_valid` is accepted, and its result follows 33 cycles later.
- R11: In ROUND, the round index drops by exactly one per cycle. ROUND leaves for EMIT only after the cycle that processes index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Key store write enable |
| key_addr | input | 8 | Key store word address (4*i+j) |
| key_wdata | input | 32 | Key word to store |
| start | input | 1 | Request to decrypt `ct_in` |
| ct_in | input | 128 | Ciphertext block, word j at bits 32j+31:32j |
| out_valid | output | 1 | One-cycle pulse marking new plaintext |
| pt_out | output | 128 | Plaintext block, held between pulses |

## Verification
The completion pulse and the acceptance of the next request can occur in the same cycle, because EMIT has already handed control back to IDLE when `out_valid` is high. The bench raises `start` with a second ciphertext exactly in the cycle where it sees `out_valid`. It then checks three things: the first plaintext stays on `pt_out` during the second run, no extra pulse appears, and the second plaintext arrives 33 cycles later. It also compares with a forward reference model, so any error in the scheduling of rounds or keys shows up.

// File: rtl/blkdec_pkg.sv
package blkdec_pkg;
    localparam int WORD_W    = 32;
    localparam int NWORDS    = 4;
    localparam int BLOCK_W   = WORD_W * NWORDS;
    localparam int ROUNDS    = 32;
    localparam int KEY_CNT   = ROUNDS + 1;
    localparam int KEY_WORDS = KEY_CNT * NWORDS;
    localparam int KADDR_W   = $clog2(KEY_WORDS);
    localparam int RND_W     = $clog2(ROUNDS);
    localparam int LATENCY   = ROUNDS + 1;
    localparam int NBOX      = 8;
    localparam int BOX_SEL_W = $clog2(NBOX);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_EMIT  = 2'd2
    } dec_state_e;

    typedef logic [WORD_W-1:0] word_t;

    // forward substitution boxes, output for input v at bits [4v+3:4v]
    localparam logic [63:0] FWD_BOX [NBOX] = '{
        64'hC90724DEB56A1F83, 64'h43D68EB1A50972CF,
        64'h25B04E1DFAC39768, 64'hE57A421D369C8BF0,
        64'hD7E9A4526B0C38F1, 64'h176D8E30C9A4B25F,
        64'h0A3DF19EB6485C27, 64'h6539AC47B28E0FD1
    };

    // inverse lookup derived by searching the forward permutation
    function automatic logic [3:0] inv_nib(input logic [BOX_SEL_W-1:0] box,
                                           input logic [3:0] y);
        logic [3:0] r;
        r = '0;
        for (int v = 0; v < 16; v++) begin
            if (FWD_BOX[box][4*v +: 4] == y) r = 4'(v);
        end
        return r;
    endfunction

    function automatic word_t rotr(input word_t v, input int n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction
endpackage

// File: rtl/blkdec_keystore.sv
module blkdec_keystore
    import blkdec_pkg::*;
(
    input  logic               clk,
    input  logic               we,
    input  logic [KADDR_W-1:0] waddr,
    input  word_t              wdata,
    input  logic [RND_W:0]     ridx,
    output logic [BLOCK_W-1:0] rkey
);
    word_t mem [KEY_WORDS];

    always_ff @(posedge clk) begin
        if (we && (waddr < KADDR_W'(KEY_WORDS))) begin
            mem[waddr] <= wdata;
        end
    end

    logic [KADDR_W-1:0] base;
    assign base = KADDR_W'(ridx) * KADDR_W'(NWORDS);

    for (genvar j = 0; j < NWORDS; j++) begin : g_rd
        assign rkey[j*WORD_W +: WORD_W] = mem[base + KADDR_W'(j)];
    end
endmodule

// File: rtl/blkdec_round.sv
module blkdec_round
    import blkdec_pkg::*;
(
    input  logic [BLOCK_W-1:0]   st_i,
    input  logic [BOX_SEL_W-1:0] box_i,
    input  logic [BLOCK_W-1:0]   key_i,
    input  logic                 mix_i,
    output logic [BLOCK_W-1:0]   st_o
);
    logic [BLOCK_W-1:0] subst;
    logic [BLOCK_W-1:0] keyed;
    logic [BLOCK_W-1:0] mixed;

    // bitsliced inverse substitution: one nibble per bit column
    for (genvar b = 0; b < WORD_W; b++) begin : g_col
        logic [3:0] col_in;
        logic [3:0] col_out;
        for (genvar k = 0; k < NWORDS; k++) begin : g_bit
            assign col_in[k]             = st_i[k*WORD_W + b];
            assign subst[k*WORD_W + b]   = col_out[k];
        end
        assign col_out = inv_nib(box_i, col_in);
    end

    assign keyed = subst ^ key_i;

    always_comb begin
        word_t a0, a1, a2, a3;
        a0 = keyed[0*WORD_W +: WORD_W];
        a1 = keyed[1*WORD_W +: WORD_W];
        a2 = keyed[2*WORD_W +: WORD_W];
        a3 = keyed[3*WORD_W +: WORD_W];
        a0 = rotr(a0, 5);
        a2 = rotr(a2, 22);
        a2 = a2 ^ a3 ^ (a1 << 7);
        a0 = a0 ^ a1 ^ a3;
        a1 = rotr(a1, 1);
        a3 = rotr(a3, 7);
        a3 = a3 ^ a2 ^ (a0 << 3);
        a1 = a1 ^ a0 ^ a2;
        a0 = rotr(a0, 13);
        a2 = rotr(a2, 3);
        mixed = {a3, a2, a1, a0};
    end

    assign st_o = mix_i ? mixed : keyed;
endmodule

// File: rtl/blkdec_core.sv
module blkdec_core
    import blkdec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_we,
    input  logic [KADDR_W-1:0] key_addr,
    input  logic [WORD_W-1:0]  key_wdata,
    input  logic               start,
    input  logic [BLOCK_W-1:0] ct_in,
    output logic               out_valid,
    output logic [BLOCK_W-1:0] pt_out
);
    dec_state_e         fsm_q, fsm_d;
    logic [RND_W-1:0]   rnd_q;
    logic [BLOCK_W-1:0] st_q;
    logic [BLOCK_W-1:0] rkey;
    logic [BLOCK_W-1:0] round_out;
    logic [RND_W:0]     kidx;
    logic               busy;
    logic               in_round;

    assign busy     = (fsm_q != ST_IDLE);
    assign in_round = (fsm_q == ST_ROUND);
    assign kidx     = in_round ? {1'b0, rnd_q} : (RND_W+1)'(ROUNDS);

    blkdec_keystore u_keys (
        .clk   (clk),
        .we    (key_we),
        .waddr (key_addr),
        .wdata (key_wdata),
        .ridx  (kidx),
        .rkey  (rkey)
    );

    blkdec_round u_round (
        .st_i  (st_q),
        .box_i (rnd_q[BOX_SEL_W-1:0]),
        .key_i (rkey),
        .mix_i (rnd_q != '0),
        .st_o  (round_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // transitions
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE:  if (start)          fsm_d = ST_ROUND;
            ST_ROUND: if (rnd_q == '0)    fsm_d = ST_EMIT;
            ST_EMIT:                      fsm_d = ST_IDLE;
            default:                      fsm_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            rnd_q     <= '0;
            out_valid <= 1'b0;
            pt_out    <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (fsm_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ct_in ^ rkey;
                        rnd_q <= RND_W'(ROUNDS - 1);
                    end
                end
                ST_ROUND: begin
                    st_q  <= round_out;
                    rnd_q <= rnd_q - 1'b1;
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    pt_out    <= st_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/blkdec_core_chk.sv
module blkdec_core_chk
    import blkdec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               out_valid,
    input logic [BLOCK_W-1:0] pt_out,
    input logic               busy,
    input logic               in_round,
    input logic [RND_W-1:0]   rnd_q
);
    logic       track;
    logic [6:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track   <= 1'b0;
            lat_cnt <= '0;
        end else if (!busy && start) begin
            track   <= 1'b1;
            lat_cnt <= '0;
        end else if (track) begin
            if (out_valid) track <= 1'b0;
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (track && lat_cnt == 7'(LATENCY)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(pt_out));

    p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_round && rnd_q != '0) |=> (in_round && rnd_q == $past(rnd_q) - 1'b1));

    p_round_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_round && rnd_q == '0) |=> (!in_round && busy));

    p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && start) |=> in_round);
endmodule

bind blkdec_core blkdec_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_valid (out_valid),
    .pt_out    (pt_out),
    .busy      (busy),
    .in_round  (in_round),
    .rnd_q     (rnd_q)
);

// File: tb/blkdec_core_bench.sv
module blkdec_core_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_we = 1'b0;
    logic [7:0]   key_addr = '0;
    logic [31:0]  key_wdata = '0;
    logic         start = 1'b0;
    logic [127:0] ct_in = '0;
    logic         out_valid;
    logic [127:0] pt_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] kw [132];

    localparam logic [63:0] TB_BOX [8] = '{
        64'hC90724DEB56A1F83, 64'h43D68EB1A50972CF,
        64'h25B04E1DFAC39768, 64'hE57A421D369C8BF0,
        64'hD7E9A4526B0C38F1, 64'h176D8E30C9A4B25F,
        64'h0A3DF19EB6485C27, 64'h6539AC47B28E0FD1
    };

    always #5 clk = ~clk;

    blkdec_core u_blkdec_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (key_we),
        .key_addr  (key_addr),
        .key_wdata (key_wdata),
        .start     (start),
        .ct_in     (ct_in),
        .out_valid (out_valid),
        .pt_out    (pt_out)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // ---------------- forward reference model ----------------
    function automatic logic [31:0] rol(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction

    function automatic logic [127:0] fwd_sub(input int box, input logic [127:0] x);
        logic [127:0] y;
        y = '0;
        for (int b = 0; b < 32; b++) begin
            logic [3:0] n, o;
            n = {x[96+b], x[64+b], x[32+b], x[b]};
            o = TB_BOX[box][4*n +: 4];
            y[b] = o[0]; y[32+b] = o[1]; y[64+b] = o[2]; y[96+b] = o[3];
        end
        return y;
    endfunction

    function automatic logic [127:0] fwd_mix(input logic [127:0] x);
        logic [31:0] a0, a1, a2, a3;
        {a3, a2, a1, a0} = x;
        a0 = rol(a0, 13); a2 = rol(a2, 3);
        a1 = a1 ^ a0 ^ a2;
        a3 = a3 ^ a2 ^ (a0 << 3);
        a1 = rol(a1, 1); a3 = rol(a3, 7);
        a0 = a0 ^ a1 ^ a3;
        a2 = a2 ^ a3 ^ (a1 << 7);
        a0 = rol(a0, 5); a2 = rol(a2, 22);
        return {a3, a2, a1, a0};
    endfunction

    function automatic logic [127:0] rkey(input int i);
        return {kw[4*i+3], kw[4*i+2], kw[4*i+1], kw[4*i]};
    endfunction

    function automatic logic [127:0] encrypt(input logic [127:0] pt);
        logic [127:0] x;
        x = pt;
        for (int r = 0; r < 32; r++) begin
            x = x ^ rkey(r);
            x = fwd_sub(r % 8, x);
            if (r < 31) x = fwd_mix(x);
            else        x = x ^ rkey(32);
        end
        return x;
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic write_key(input int addr, input logic [31:0] data);
        @(negedge clk);
        key_we = 1'b1; key_addr = 8'(addr); key_wdata = data;
        @(negedge clk);
        key_we = 1'b0;
        if (addr < 132) kw[addr] = data;
    endtask

    task automatic load_random_keys();
        for (int a = 0; a < 132; a++) write_key(a, $urandom());
    endtask

    // start at a negedge, counts edges after the accepting edge until out_valid
    task automatic run_dec(input logic [127:0] ct, output logic [127:0] pt, output int lat);
        @(negedge clk);
        ct_in = ct; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        pt = pt_out;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 out_valid in reset", 128'(out_valid), 128'(0));
        check("R1 pt_out in reset", pt_out, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 128'(out_valid), 128'(0));
        check("R1 pt_out after reset", pt_out, '0);
    endtask

    task automatic t_box_inverse();
        for (int k = 0; k < 8; k++) begin
            int bad;
            bad = 0;
            for (int v = 0; v < 16; v++) begin
                logic [3:0] y;
                y = TB_BOX[k][4*v +: 4];
                if (blkdec_pkg::inv_nib(3'(k), y) != 4'(v)) bad++;
            end
            check($sformatf("R6 inverse box %0d mismatches", k), 128'(bad), 128'(0));
        end
    endtask

    task automatic t_patterns();
        logic [127:0] pts [3];
        pts[0] = '0;
        pts[1] = '1;
        pts[2] = 128'h00000003_00000002_00000001_00000000; // R8 word order
        for (int i = 0; i < 3; i++) begin
            logic [127:0] got;
            int lat;
            run_dec(encrypt(pts[i]), got, lat);
            check($sformatf("R4 R5 R8 pattern %0d", i), got, pts[i]);
            check("R3 latency", 128'(lat), 128'(33));
            @(negedge clk);
            check("R3 single-cycle pulse", 128'(out_valid), 128'(0));
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 6; i++) begin
            logic [127:0] pt, got;
            int lat;
            pt = {$urandom(), $urandom(), $urandom(), $urandom()};
            run_dec(encrypt(pt), got, lat);
            check($sformatf("R4 R6 random block %0d", i), got, pt);
        end
    endtask

    task automatic t_key_rewrite();
        logic [127:0] pt, got;
        int lat;
        pt = 128'h0123456789ABCDEF_FEDCBA9876543210;
        write_key(4*17 + 2, 32'hDEADBEEF);   // word 2 of key 17
        write_key(4*32 + 0, 32'h13579BDF);   // word 0 of key 32
        write_key(200, 32'hFFFFFFFF);        // out of range, dropped
        run_dec(encrypt(pt), got, lat);
        check("R7 rewritten keys used", got, pt);
    endtask

    task automatic t_busy_ignore();
        logic [127:0] pt1, pt2, got;
        int lat, extra;
        pt1 = {$urandom(), $urandom(), $urandom(), $urandom()};
        pt2 = ~pt1;
        @(negedge clk);
        ct_in = encrypt(pt1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!out_valid && lat < 100) begin
            if (lat == 10 || lat == 32) begin
                ct_in = encrypt(pt2); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        got = pt_out;
        check("R2 result unaffected by busy start", got, pt1);
        check("R2 latency unaffected", 128'(lat), 128'(33));
        extra = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        check("R2 no pulse from ignored start", 128'(extra), 128'(0));
    endtask

    task automatic t_back_to_back();
        logic [127:0] pt1, pt2, got;
        int lat;
        pt1 = {$urandom(), $urandom(), $urandom(), $urandom()};
        pt2 = {$urandom(), $urandom(), $urandom(), $urandom()};
        run_dec(encrypt(pt1), got, lat);
        check("R10 first block", got, pt1);
        // still in the out_valid cycle: request the next block now
        ct_in = encrypt(pt2); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 pulse ends", 128'(out_valid), 128'(0));
        lat = 0;
        while (!out_valid && lat < 100) begin
            if (lat == 16) check("R9 pt_out held mid-run", pt_out, pt1);
            @(negedge clk);
            lat++;
        end
        check("R10 second latency", 128'(lat), 128'(33));
        check("R10 R11 second block", pt_out, pt2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < 132; a++) kw[a] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_box_inverse();
        load_random_keys();
        t_patterns();
        t_random();
        t_key_rewrite();
        t_busy_ignore();
        t_back_to_back();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule